// File: doc/BRIEF.md
# Two-Stage Channel Attenuation Splitter

This block sets the attenuation of one RF channel. Each channel has two step-attenuator stages in cascade. A request gives a channel number and a total attenuation in quarter-dB. The block checks the request, divides the total between the two stages and then hands two write commands, one after the other, to a downstream stage loader. The stage loader does the serial shifting and acknowledges each command with a one-cycle done pulse. A mode input selects the split policy. One policy halves the total. The other fills stage 1 up to its cap before it gives anything to stage 2.

The block keeps the last value written to every stage, together with a fixed power-up value per stage. A separate read port returns the total attenuation of a channel: the sum over its stages of either the current values or the power-up values. A bad channel number on either port is answered with a no-device code instead of a result.

Top module: `chan_atten_split`

## Requirements
- R1: A set request whose channel is 0 or above NUM_CH finishes one cycle after acceptance with `set_done`=1 and `set_err`=1 (no device). No loader command is issued. This check takes precedence over the range check.
- R2: A set request on a valid channel whose total divided by 4 (integer) exceeds 63, that is a total of 256 or more, finishes one cycle after acceptance with `set_err`=2 (range). No loader command is issued and no stored value changes.
- R3: With `set_equal`=1, stage 1 receives floor(total/2).
- R4: With `set_equal`=0, stage 1 receives the total if it is below 124 and exactly 124 otherwise.
- R5: Stage 2 receives the total minus the stage 1 amount, with no further clamping, so an odd quarter goes to stage 2.
- R6: The stage 1 command (`ld_stage`=0) appears one cycle after acceptance as a one-cycle `ld_valid` pulse. The stage 2 command (`ld_stage`=1) appears only in the cycle after the loader's `ld_done` for stage 1. `set_done` with `set_err`=0 follows the cycle after the `ld_done` for stage 2.
- R7: `set_ready` is low from acceptance until `set_done`. A set request presented while `set_ready` is low is ignored.
- R8: A read request gives `rd_done`=1 one cycle later. `rd_sum` (9 bits) is then the sum of both stage values of the channel: the current values when `rd_sel`=0, the power-up values when `rd_sel`=1. `rd_err`=0.
- R9: A read request for channel 0 or above NUM_CH gives `rd_err`=1 and `rd_sum`=0.
- R10: After reset, `set_ready`=1, and `set_done`, `ld_valid` and `rd_done` are 0. Every stage's current value equals its power-up value: stage 1 is 40 and stage 2 is 20 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | Set request strobe |
| set_ready | output | 1 | Block can accept a set request |
| set_chan | input | 4 | Channel number, 1-based |
| set_total_qdb | input | 9 | Requested total attenuation in quarter-dB |
| set_equal | input | 1 | 1 = halve, 0 = fill stage 1 first |
| set_done | output | 1 | One-cycle completion pulse |
| set_err | output | 2 | 0 ok, 1 no device, 2 range |
| ld_valid | output | 1 | One-cycle stage write command to loader |
| ld_chan | output | 4 | Channel of the command |
| ld_stage | output | 1 | 0 = stage 1, 1 = stage 2 |
| ld_qdb | output | 8 | Stage value in quarter-dB |
| ld_done | input | 1 | Loader finished the last command |
| rd_valid | input | 1 | Read request strobe |
| rd_chan | input | 4 | Channel to read, 1-based |
| rd_sel | input | 1 | 0 = current values, 1 = power-up values |
| rd_done | output | 1 | Read result valid |
| rd_err | output | 2 | 0 ok, 1 no device |
| rd_sum | output | 9 | Summed attenuation in quarter-dB |

## Verification
The hardest situation to reach from the ports is the interval between the two loader commands. In that interval the block is busy and waits on the loader. This is where the ordering and busy rules must hold. The bench plays the loader itself and holds back `ld_done` for several cycles. In that gap it checks that no stage 2 command leaks out, and it fires a competing set request that must leave no trace. A later channel read then shows which value landed. Rejected requests are followed by reads of the same channel, which show that they changed nothing.

// File: rtl/chan_atten_pkg.sv
package chan_atten_pkg;
  typedef enum logic [1:0] {
    ERR_OK    = 2'd0,
    ERR_NODEV = 2'd1,
    ERR_RANGE = 2'd2
  } att_err_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WAIT1 = 2'd1,
    SQ_WAIT2 = 2'd2
  } seq_state_e;
endpackage

// File: rtl/catt_split.sv
// Combinational range check and stage split.
module catt_split #(
  parameter int VAL_W        = 8,
  parameter int STAGE_CAP    = 124,
  parameter int MAX_WHOLE_DB = 63,
  localparam int REQ_W       = VAL_W + 1
) (
  input  logic [REQ_W-1:0] total,
  input  logic             equal,
  output logic [VAL_W-1:0] s1,
  output logic [VAL_W-1:0] s2,
  output logic             range_bad
);
  always_comb begin
    range_bad = (int'(total[REQ_W-1:2]) > MAX_WHOLE_DB);
    if (equal)
      s1 = total[VAL_W:1];
    else if (int'(total) < STAGE_CAP)
      s1 = total[VAL_W-1:0];
    else
      s1 = VAL_W'(STAGE_CAP);
    s2 = total[VAL_W-1:0] - s1;
  end
endmodule

// File: rtl/catt_seq.sv
// Sequencer: accept, reject or issue two ordered loader commands.
module catt_seq
  import chan_atten_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_valid,
  input  logic [CH_W-1:0]  set_chan,
  input  logic             chan_ok,
  input  logic             range_bad,
  input  logic [VAL_W-1:0] s1,
  input  logic [VAL_W-1:0] s2,
  output logic             set_ready,
  output logic             set_done,
  output logic [1:0]       set_err,
  output logic             ld_valid,
  output logic [CH_W-1:0]  ld_chan,
  output logic             ld_stage,
  output logic [VAL_W-1:0] ld_qdb,
  input  logic             ld_done,
  output logic             wr_en,
  output logic [CH_W-1:0]  wr_chan,
  output logic             wr_stage,
  output logic [VAL_W-1:0] wr_val
);
  seq_state_e       state_q;
  logic [VAL_W-1:0] s1_q, s2_q;

  assign set_ready = (state_q == SQ_IDLE);

  // store update follows each loader acknowledgement
  assign wr_en    = ld_done && (state_q != SQ_IDLE);
  assign wr_chan  = ld_chan;
  assign wr_stage = (state_q == SQ_WAIT2);
  assign wr_val   = (state_q == SQ_WAIT2) ? s2_q : s1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      s1_q     <= '0;
      s2_q     <= '0;
      set_done <= 1'b0;
      set_err  <= ERR_OK;
      ld_valid <= 1'b0;
      ld_chan  <= '0;
      ld_stage <= 1'b0;
      ld_qdb   <= '0;
    end else begin
      set_done <= 1'b0;
      ld_valid <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (set_valid) begin
            if (!chan_ok) begin
              set_done <= 1'b1;
              set_err  <= ERR_NODEV;
            end else if (range_bad) begin
              set_done <= 1'b1;
              set_err  <= ERR_RANGE;
            end else begin
              s1_q     <= s1;
              s2_q     <= s2;
              ld_valid <= 1'b1;
              ld_chan  <= set_chan;
              ld_stage <= 1'b0;
              ld_qdb   <= s1;
              state_q  <= SQ_WAIT1;
            end
          end
        end
        SQ_WAIT1: begin
          if (ld_done) begin
            ld_valid <= 1'b1;
            ld_stage <= 1'b1;
            ld_qdb   <= s2_q;
            state_q  <= SQ_WAIT2;
          end
        end
        SQ_WAIT2: begin
          if (ld_done) begin
            set_done <= 1'b1;
            set_err  <= ERR_OK;
            state_q  <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/catt_store.sv
// Per-stage value registers and summed channel read-back.
module catt_store
  import chan_atten_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int CH_W       = 4,
  parameter int VAL_W      = 8,
  parameter int SUM_W      = 9,
  parameter int STARTUP_S1 = 40,
  parameter int STARTUP_S2 = 20,
  localparam int NUM_STG   = 2,
  localparam int IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic             wr_stage,
  input  logic [VAL_W-1:0] wr_val,
  input  logic             rd_valid,
  input  logic [CH_W-1:0]  rd_chan,
  input  logic             rd_chan_ok,
  input  logic             rd_sel,
  output logic             rd_done,
  output logic [1:0]       rd_err,
  output logic [SUM_W-1:0] rd_sum
);
  localparam logic [VAL_W-1:0] BOOT [NUM_STG] = '{VAL_W'(STARTUP_S1), VAL_W'(STARTUP_S2)};

  logic [VAL_W-1:0] cur_q [NUM_CH][NUM_STG];
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [SUM_W-1:0] acc;

  assign wr_idx = IDX_W'(wr_chan - CH_W'(1));
  assign rd_idx = IDX_W'(rd_chan - CH_W'(1));

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
        always_ff @(posedge clk) begin
          if (rst)
            cur_q[c][s] <= BOOT[s];
          else if (wr_en && (int'(wr_idx) == c) && (int'(wr_stage) == s))
            cur_q[c][s] <= wr_val;
        end
      end
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int s = 0; s < NUM_STG; s++)
      acc = acc + SUM_W'(rd_sel ? BOOT[s] : cur_q[rd_idx][s]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_done <= 1'b0;
      rd_err  <= ERR_OK;
      rd_sum  <= '0;
    end else begin
      rd_done <= rd_valid;
      if (rd_valid) begin
        rd_err <= rd_chan_ok ? ERR_OK : ERR_NODEV;
        rd_sum <= rd_chan_ok ? acc : '0;
      end
    end
  end
endmodule

// File: rtl/chan_atten_split.sv
module chan_atten_split #(
  parameter int NUM_CH       = 8,
  parameter int VAL_W        = 8,
  parameter int STAGE_CAP    = 124,
  parameter int MAX_WHOLE_DB = 63,
  parameter int STARTUP_S1   = 40,
  parameter int STARTUP_S2   = 20,
  localparam int CH_W        = $clog2(NUM_CH + 1),
  localparam int REQ_W       = VAL_W + 1,
  localparam int SUM_W       = VAL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_valid,
  output logic             set_ready,
  input  logic [CH_W-1:0]  set_chan,
  input  logic [REQ_W-1:0] set_total_qdb,
  input  logic             set_equal,
  output logic             set_done,
  output logic [1:0]       set_err,
  output logic             ld_valid,
  output logic [CH_W-1:0]  ld_chan,
  output logic             ld_stage,
  output logic [VAL_W-1:0] ld_qdb,
  input  logic             ld_done,
  input  logic             rd_valid,
  input  logic [CH_W-1:0]  rd_chan,
  input  logic             rd_sel,
  output logic             rd_done,
  output logic [1:0]       rd_err,
  output logic [SUM_W-1:0] rd_sum
);
  logic [VAL_W-1:0] s1, s2;
  logic             range_bad, set_chan_ok, rd_chan_ok;
  logic             wr_en, wr_stage;
  logic [CH_W-1:0]  wr_chan;
  logic [VAL_W-1:0] wr_val;

  assign set_chan_ok = (set_chan != '0) && (int'(set_chan) <= NUM_CH);
  assign rd_chan_ok  = (rd_chan  != '0) && (int'(rd_chan)  <= NUM_CH);

  catt_split #(.VAL_W(VAL_W), .STAGE_CAP(STAGE_CAP), .MAX_WHOLE_DB(MAX_WHOLE_DB)) split_i (
    .total(set_total_qdb), .equal(set_equal), .s1(s1), .s2(s2), .range_bad(range_bad)
  );

  catt_seq #(.CH_W(CH_W), .VAL_W(VAL_W)) seq_i (
    .clk(clk), .rst(rst), .set_valid(set_valid), .set_chan(set_chan),
    .chan_ok(set_chan_ok), .range_bad(range_bad), .s1(s1), .s2(s2),
    .set_ready(set_ready), .set_done(set_done), .set_err(set_err),
    .ld_valid(ld_valid), .ld_chan(ld_chan), .ld_stage(ld_stage), .ld_qdb(ld_qdb),
    .ld_done(ld_done), .wr_en(wr_en), .wr_chan(wr_chan), .wr_stage(wr_stage),
    .wr_val(wr_val)
  );

  catt_store #(.NUM_CH(NUM_CH), .CH_W(CH_W), .VAL_W(VAL_W), .SUM_W(SUM_W),
               .STARTUP_S1(STARTUP_S1), .STARTUP_S2(STARTUP_S2)) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan), .wr_stage(wr_stage),
    .wr_val(wr_val), .rd_valid(rd_valid), .rd_chan(rd_chan), .rd_chan_ok(rd_chan_ok),
    .rd_sel(rd_sel), .rd_done(rd_done), .rd_err(rd_err), .rd_sum(rd_sum)
  );
endmodule

// File: rtl/chan_atten_split_chk.sv
module chan_atten_split_chk #(
  parameter int NUM_CH    = 8,
  parameter int VAL_W     = 8,
  parameter int STAGE_CAP = 124,
  localparam int CH_W     = $clog2(NUM_CH + 1),
  localparam int REQ_W    = VAL_W + 1,
  localparam int SUM_W    = VAL_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             set_valid,
  input logic             set_ready,
  input logic [CH_W-1:0]  set_chan,
  input logic [REQ_W-1:0] set_total_qdb,
  input logic             set_equal,
  input logic             set_done,
  input logic [1:0]       set_err,
  input logic             ld_valid,
  input logic [CH_W-1:0]  ld_chan,
  input logic             ld_stage,
  input logic [VAL_W-1:0] ld_qdb,
  input logic             ld_done,
  input logic             rd_valid,
  input logic [CH_W-1:0]  rd_chan,
  input logic             rd_sel,
  input logic             rd_done,
  input logic [1:0]       rd_err,
  input logic [SUM_W-1:0] rd_sum
);
  logic             req_chan_ok, rd_ok, accept;
  logic [REQ_W-1:0] tot_q;
  logic             mode_q;
  logic [VAL_W-1:0] first_q;

  assign req_chan_ok = (set_chan != '0) && (int'(set_chan) <= NUM_CH);
  assign rd_ok       = (rd_chan  != '0) && (int'(rd_chan)  <= NUM_CH);
  assign accept      = set_valid && set_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      tot_q   <= '0;
      mode_q  <= 1'b0;
      first_q <= '0;
    end else begin
      if (accept) begin
        tot_q  <= set_total_qdb;
        mode_q <= set_equal;
      end
      if (ld_valid && !ld_stage)
        first_q <= ld_qdb;
    end
  end

  AST_NODEV_REJECT: assert property (@(posedge clk) disable iff (rst)
    accept && !req_chan_ok |=> set_done && set_err == 2'd1 && !ld_valid); // R1
  AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (rst)
    accept && req_chan_ok && set_total_qdb >= REQ_W'(256) |=> set_done && set_err == 2'd2 && !ld_valid); // R2
  AST_EQUAL_HALF: assert property (@(posedge clk) disable iff (rst)
    accept && req_chan_ok && set_total_qdb < REQ_W'(256) && set_equal
      |=> ld_valid && !ld_stage && REQ_W'(ld_qdb) == ($past(set_total_qdb) >> 1)); // R3
  AST_FILL_CAP: assert property (@(posedge clk) disable iff (rst)
    ld_valid && !ld_stage && !mode_q |-> int'(ld_qdb) <= STAGE_CAP); // R4
  AST_SPLIT_SUM: assert property (@(posedge clk) disable iff (rst)
    ld_valid && ld_stage |-> REQ_W'(first_q) + REQ_W'(ld_qdb) == tot_q); // R5
  AST_DONE_AFTER_S2: assert property (@(posedge clk) disable iff (rst)
    set_done && set_err == 2'd0 |-> ld_stage && !ld_valid); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    set_valid && !set_ready |=> !(ld_valid && !ld_stage)); // R7
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_done); // R8
  AST_RD_NODEV: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ok |=> rd_err == 2'd1 && rd_sum == '0); // R9
endmodule

bind chan_atten_split chan_atten_split_chk #(
  .NUM_CH(NUM_CH), .VAL_W(VAL_W), .STAGE_CAP(STAGE_CAP)
) chk_i (.*);

// File: tb/chan_atten_split_tb_top.sv
module chan_atten_split_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       set_valid = 1'b0, set_equal = 1'b0;
  logic [3:0] set_chan = '0;
  logic [8:0] set_total_qdb = '0;
  logic       set_ready, set_done, ld_valid, ld_stage;
  logic [1:0] set_err, rd_err;
  logic [3:0] ld_chan;
  logic [7:0] ld_qdb;
  logic       ld_done = 1'b0;
  logic       rd_valid = 1'b0, rd_sel = 1'b0;
  logic [3:0] rd_chan = '0;
  logic       rd_done;
  logic [8:0] rd_sum;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_atten_split dut_i (
    .clk(clk), .rst(rst), .set_valid(set_valid), .set_ready(set_ready),
    .set_chan(set_chan), .set_total_qdb(set_total_qdb), .set_equal(set_equal),
    .set_done(set_done), .set_err(set_err), .ld_valid(ld_valid), .ld_chan(ld_chan),
    .ld_stage(ld_stage), .ld_qdb(ld_qdb), .ld_done(ld_done), .rd_valid(rd_valid),
    .rd_chan(rd_chan), .rd_sel(rd_sel), .rd_done(rd_done), .rd_err(rd_err),
    .rd_sum(rd_sum)
  );

  // {chan[4], total[9], equal[1], err[2], stage1[8], stage2[8]}
  localparam logic [31:0] VEC [NVEC] = '{
    {4'd1,  9'd100, 1'b1, 2'd0, 8'd50,  8'd50 },  // R3 even halves
    {4'd2,  9'd101, 1'b1, 2'd0, 8'd50,  8'd51 },  // R5 odd to stage 2
    {4'd3,  9'd200, 1'b0, 2'd0, 8'd124, 8'd76 },  // R4 cap
    {4'd4,  9'd124, 1'b0, 2'd0, 8'd124, 8'd0  },  // R4 exactly cap
    {4'd5,  9'd123, 1'b0, 2'd0, 8'd123, 8'd0  },  // R4 below cap
    {4'd8,  9'd255, 1'b0, 2'd0, 8'd124, 8'd131},  // R5 no reclamp
    {4'd6,  9'd255, 1'b1, 2'd0, 8'd127, 8'd128},  // R3 max halves
    {4'd0,  9'd10,  1'b1, 2'd1, 8'd0,   8'd0  },  // R1 channel 0
    {4'd9,  9'd10,  1'b0, 2'd1, 8'd0,   8'd0  },  // R1 above range
    {4'd1,  9'd256, 1'b1, 2'd2, 8'd0,   8'd0  },  // R2 just over
    {4'd15, 9'd300, 1'b0, 2'd1, 8'd0,   8'd0  },  // R1 precedence
    {4'd7,  9'd252, 1'b0, 2'd0, 8'd124, 8'd128}   // R2 edge 63 dB accepted
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_done(input int gap);
    repeat (gap) @(negedge clk);
    ld_done = 1'b1;
    @(negedge clk);
    ld_done = 1'b0;
  endtask

  task automatic run_set(input int ch, input int tot, input bit eq, input int e_err,
                         input int e1, input int e2);
    @(negedge clk);
    set_valid = 1'b1; set_chan = 4'(ch); set_total_qdb = 9'(tot); set_equal = eq;
    @(negedge clk);
    set_valid = 1'b0;
    if (e_err != 0) begin
      chk(set_done == 1'b1 && 32'(set_err) == e_err && !ld_valid,
          (e_err == 1) ? "R1" : "R2", "reject code", int'(set_err), e_err);
    end else begin
      chk(ld_valid && !ld_stage && int'(ld_qdb) == e1 && int'(ld_chan) == ch,
          eq ? "R3" : "R4", "stage1 value", int'(ld_qdb), e1);
      chk(!set_ready, "R7", "busy after accept", int'(set_ready), 0);
      repeat (3) @(negedge clk);
      chk(!ld_valid, "R6", "no stage2 before done", int'(ld_valid), 0);
      pulse_done(0);
      chk(ld_valid && ld_stage && int'(ld_qdb) == e2, "R5", "stage2 value",
          int'(ld_qdb), e2);
      chk(!set_done, "R6", "not done before stage2 ack", int'(set_done), 0);
      pulse_done(2);
      chk(set_done && set_err == 2'd0 && set_ready, "R6", "done ok",
          int'(set_done), 1);
    end
  endtask

  task automatic run_rd(input int ch, input bit sel, input int e_err, input int e_sum,
                        input string req);
    @(negedge clk);
    rd_valid = 1'b1; rd_chan = 4'(ch); rd_sel = sel;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rd_done && 32'(rd_err) == e_err, req, "read code", int'(rd_err), e_err);
    chk(int'(rd_sum) == e_sum, req, "read sum", int'(rd_sum), e_sum);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(set_ready && !set_done && !ld_valid && !rd_done, "R10", "idle after reset",
        int'({set_ready, set_done, ld_valid, rd_done}), 8);
    run_rd(4, 1'b0, 0, 60, "R10");
    run_rd(2, 1'b1, 0, 60, "R8");

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      v = VEC[i];
      run_set(int'(v[31:28]), int'(v[27:19]), v[18], int'(v[17:16]),
              int'(v[15:8]), int'(v[7:0]));
    end

    // R2: rejected range request on ch1 left the earlier 50+50 in place
    run_rd(1, 1'b0, 0, 100, "R2");
    run_rd(8, 1'b0, 0, 255, "R8");
    run_rd(3, 1'b0, 0, 200, "R8");
    run_rd(2, 1'b1, 0, 60,  "R8");
    run_rd(0, 1'b0, 1, 0,   "R9");
    run_rd(9, 1'b1, 1, 0,   "R9");

    // R7: a request while busy is ignored
    @(negedge clk);
    set_valid = 1'b1; set_chan = 4'd2; set_total_qdb = 9'd40; set_equal = 1'b1;
    @(negedge clk);
    set_chan = 4'd2; set_total_qdb = 9'd200; set_equal = 1'b0;
    @(negedge clk);
    set_valid = 1'b0;
    chk(!ld_valid, "R7", "no command from busy request", int'(ld_valid), 0);
    pulse_done(1);
    chk(ld_valid && ld_stage && ld_qdb == 8'd20, "R7", "stage2 of first request",
        int'(ld_qdb), 20);
    pulse_done(1);
    chk(set_done && set_err == 2'd0, "R7", "first request done", int'(set_err), 0);
    repeat (3) @(negedge clk);
    chk(!ld_valid && set_ready, "R7", "no late command", int'(ld_valid), 0);
    run_rd(2, 1'b0, 0, 40, "R7");

    // R10: reset restores power-up values
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    run_rd(8, 1'b0, 0, 60, "R10");

    finish_run();
  end
endmodule